// File: doc/BRIEF.md
# Dual-Bank IRQ/FIQ Interrupt Controller

This block collects 40 level-sensitive interrupt sources for a processor core that has two interrupt inputs: a normal-priority IRQ and a fast FIQ. Sources are organised as two banks. Bank 0 holds sources 0 to 31 and bank 1 holds sources 32 to 39. Each source has an enable bit and a routing bit, and the routing bit sends the source to IRQ when clear and to FIQ when set. The block drives the two interrupt lines and a wake request that brings a halted core out of idle.

Software reaches the block through a single-cycle register bus. It sees the raw and the masked pending state of each bank, and it sets the enable and routing bits and an idle-wake qualifier. The bus also holds a 40-entry priority table. A resolver submodule walks the table and reports, in one register, the highest-priority active FIQ source and the highest-priority active IRQ source.

Pending bits, the registers and a registered copy of the halt input all change on the clock edge. The output lines are decoded from that state, so they settle one clock after an input change or a register write.

Top module: `dual_bank_intc`

## Requirements
- R1: Source n for n < 32 appears as bit n of the raw pending word at offset 0x10. Source n for 32 <= n < 40 appears as bit n-32 of the raw pending word at 0xAC, and bits 31:8 of that word read 0.
- R2: A pending bit copies its source input at each clock edge. It is set while the input is high and clear while the input is low, and nothing latches it. Writes to 0x10 and 0xAC have no effect.
- R3: `fiq_o` is high when some source is pending, enabled and routed to FIQ. `irq_o` is high when some source is pending, enabled and routed to IRQ. Both follow an input change or a register write one clock later.
- R4: Offsets 0x00 (bank 0) and 0x9C (bank 1) read pending AND enable AND NOT route. Offsets 0x0C (bank 0) and 0xA8 (bank 1) read pending AND enable AND route.
- R5: The enable words are at 0x04 (bank 0) and 0xA0 (bank 1). The routing words are at 0x08 (bank 0) and 0xA4 (bank 1), and a routing bit of 1 selects FIQ. All four are read/write. In the bank-1 words only bits 7:0 are stored, and bits 31:8 read 0.
- R6: Bit 0 of the control word at 0x14 is stored, and the other bits read 0. When the bit is 1, only enabled pending sources can wake the core. When it is 0, any pending source can wake the core.
- R7: `wake_o` can be high only while the registered halt input is high. The halt input takes effect one clock after it changes.
- R8: Priority entry i sits at 0x1C+4i for i < 32 and at 0xB0+4(i-32) for 32 <= i < 40. A write stores bit 31 (the valid flag) and bits 5:0 (the source ID). All other bits read back 0.
- R9: Offset 0x18 reports the highest-priority active sources. Bit 15 is the FIQ valid flag and bits 5:0 are the FIQ source ID. Bit 31 is the IRQ valid flag and bits 21:16 are the IRQ source ID. The winner is the lowest-indexed priority entry that is valid, has an ID below 40, and whose source is active on that line. When a line has no winner, its ID field reads 0x3F and its valid flag reads 0. A write to 0x18 has no effect.
- R10: Reads of unmapped or unaligned offsets return 0, and writes to them change nothing.
- R11: Reset clears pending, enable, routing, control and every priority entry, and holds all three output lines low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 40 | Interrupt source levels |
| halted_i | input | 1 | Core is halted in idle |
| bus_valid_i | input | 1 | Bus access this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the same cycle as a read |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |
| wake_o | output | 1 | Wake-from-idle request |

## Verification
The assertions assume that the bus presents a stable address and a stable direction in any cycle where valid is high. They also assume that the source and halt levels change only between clock edges. The bench drives every input on the falling edge and holds valid for one cycle per access, which meets both assumptions. The bench samples read data combinationally shortly after the drive, and it samples line outputs one full cycle after the stimulus. The priority checks place valid and invalid entries, including an entry whose ID is out of range, in front of real winners, so that the lowest-index rule is exercised directly.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ID_W   = 6;

  localparam logic [ADDR_W-1:0] OFF_IRQ0  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_EN0   = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_RTE0  = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_FIQ0  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_RAW0  = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_TOP   = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_PRI_A = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_IRQ1  = 8'h9C;
  localparam logic [ADDR_W-1:0] OFF_EN1   = 8'hA0;
  localparam logic [ADDR_W-1:0] OFF_RTE1  = 8'hA4;
  localparam logic [ADDR_W-1:0] OFF_FIQ1  = 8'hA8;
  localparam logic [ADDR_W-1:0] OFF_RAW1  = 8'hAC;
  localparam logic [ADDR_W-1:0] OFF_PRI_B = 8'hB0;

  typedef struct packed {
    logic            valid;
    logic [ID_W-1:0] id;
  } prio_ent_t;
endpackage

// File: rtl/intc_prio_table.sv
module intc_prio_table
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 40
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output prio_ent_t [NUM_SRC-1:0]   ent_o,
  output logic                      hit_o,
  output logic [DATA_W-1:0]         rdata_o
);
  localparam int unsigned LOW_N = (NUM_SRC < 32) ? NUM_SRC : 32;

  logic [NUM_SRC-1:0] sel;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_ent
    localparam logic [ADDR_W-1:0] ENT_ADDR = (i < LOW_N)
      ? ADDR_W'(int'(OFF_PRI_A) + 4 * i)
      : ADDR_W'(int'(OFF_PRI_B) + 4 * (i - 32));
    assign sel[i] = (addr_i == ENT_ADDR);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ent_o[i] <= '0;
      else if (wr_i && sel[i]) ent_o[i] <= '{valid: wdata_i[31], id: wdata_i[ID_W-1:0]};
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (sel[i]) rdata_o = {ent_o[i].valid, {(DATA_W-1-ID_W){1'b0}}, ent_o[i].id};
  end

  assign hit_o = |sel;

  assert_prio_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && hit_o) |=> $stable(ent_o));
endmodule

// File: rtl/intc_resolver.sv
module intc_resolver
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 40
) (
  input  prio_ent_t [NUM_SRC-1:0] ent_i,
  input  logic [NUM_SRC-1:0]      fiq_act_i,
  input  logic [NUM_SRC-1:0]      irq_act_i,
  output logic [DATA_W-1:0]       top_o
);
  localparam int unsigned PAD_W = 16 - 1 - ID_W;

  logic            f_hit, i_hit;
  logic [ID_W-1:0] f_id, i_id;

  // walk from the back so the lowest index is written last and wins
  always_comb begin
    f_hit = 1'b0;
    i_hit = 1'b0;
    f_id  = '1;
    i_id  = '1;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (ent_i[i].valid && (32'(ent_i[i].id) < NUM_SRC)) begin
        if (fiq_act_i[ent_i[i].id]) begin
          f_hit = 1'b1;
          f_id  = ent_i[i].id;
        end
        if (irq_act_i[ent_i[i].id]) begin
          i_hit = 1'b1;
          i_id  = ent_i[i].id;
        end
      end
    end
  end

  assign top_o = {i_hit, {PAD_W{1'b0}}, i_id, f_hit, {PAD_W{1'b0}}, f_id};
endmodule

// File: rtl/intc_line_gen.sv
module intc_line_gen #(
  parameter int unsigned NUM_SRC = 40
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic [NUM_SRC-1:0] rte_i,
  input  logic               idle_all_i,
  input  logic               halted_i,
  output logic [NUM_SRC-1:0] fiq_act_o,
  output logic [NUM_SRC-1:0] irq_act_o,
  output logic               irq_o,
  output logic               fiq_o,
  output logic               wake_o
);
  logic [NUM_SRC-1:0] live;

  assign live      = pend_i & en_i;
  assign fiq_act_o = live & rte_i;
  assign irq_act_o = live & ~rte_i;
  assign fiq_o     = |fiq_act_o;
  assign irq_o     = |irq_act_o;
  assign wake_o    = halted_i && |(pend_i & (en_i | {NUM_SRC{idle_all_i}}));

  assert_lines_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0) |-> (!irq_o && !fiq_o));
  assert_wake_halt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !halted_i |-> !wake_o);
  assert_wake_enabled_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_i && (irq_o || fiq_o)) |-> wake_o);
endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 40
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               halted_i,
  input  logic               bus_valid_i,
  input  logic               bus_write_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic               irq_o,
  output logic               fiq_o,
  output logic               wake_o
);
  localparam int unsigned B0_W = 32;
  localparam int unsigned B1_W = NUM_SRC - B0_W;

  logic [NUM_SRC-1:0] pend_q, en_q, rte_q;
  logic               ctrl_q, halt_q;
  logic               wr;
  logic [NUM_SRC-1:0] fiq_act, irq_act;
  prio_ent_t [NUM_SRC-1:0] ent;
  logic               pri_hit;
  logic [DATA_W-1:0]  pri_rd, top_word;
  logic               map_hit;
  logic [DATA_W-1:0]  rd_mux;

  assign wr = bus_valid_i && bus_write_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      halt_q <= 1'b0;
    end else begin
      pend_q <= src_i;
      halt_q <= halted_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      rte_q  <= '0;
      ctrl_q <= 1'b0;
    end else if (wr) begin
      unique case (bus_addr_i)
        OFF_EN0:  en_q[B0_W-1:0]        <= bus_wdata_i[B0_W-1:0];
        OFF_EN1:  en_q[NUM_SRC-1:B0_W]  <= bus_wdata_i[B1_W-1:0];
        OFF_RTE0: rte_q[B0_W-1:0]       <= bus_wdata_i[B0_W-1:0];
        OFF_RTE1: rte_q[NUM_SRC-1:B0_W] <= bus_wdata_i[B1_W-1:0];
        OFF_CTRL: ctrl_q                <= bus_wdata_i[0];
        default: ;
      endcase
    end
  end

  intc_prio_table #(.NUM_SRC(NUM_SRC)) u_prio (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .ent_o   (ent),
    .hit_o   (pri_hit),
    .rdata_o (pri_rd)
  );

  intc_line_gen #(.NUM_SRC(NUM_SRC)) u_lines (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pend_i     (pend_q),
    .en_i       (en_q),
    .rte_i      (rte_q),
    .idle_all_i (!ctrl_q),
    .halted_i   (halt_q),
    .fiq_act_o  (fiq_act),
    .irq_act_o  (irq_act),
    .irq_o      (irq_o),
    .fiq_o      (fiq_o),
    .wake_o     (wake_o)
  );

  intc_resolver #(.NUM_SRC(NUM_SRC)) u_resolve (
    .ent_i     (ent),
    .fiq_act_i (fiq_act),
    .irq_act_i (irq_act),
    .top_o     (top_word)
  );

  always_comb begin
    map_hit = 1'b1;
    rd_mux  = '0;
    unique case (bus_addr_i)
      OFF_IRQ0: rd_mux = irq_act[B0_W-1:0];
      OFF_FIQ0: rd_mux = fiq_act[B0_W-1:0];
      OFF_RAW0: rd_mux = pend_q[B0_W-1:0];
      OFF_EN0:  rd_mux = en_q[B0_W-1:0];
      OFF_RTE0: rd_mux = rte_q[B0_W-1:0];
      OFF_IRQ1: rd_mux = DATA_W'(irq_act[NUM_SRC-1:B0_W]);
      OFF_FIQ1: rd_mux = DATA_W'(fiq_act[NUM_SRC-1:B0_W]);
      OFF_RAW1: rd_mux = DATA_W'(pend_q[NUM_SRC-1:B0_W]);
      OFF_EN1:  rd_mux = DATA_W'(en_q[NUM_SRC-1:B0_W]);
      OFF_RTE1: rd_mux = DATA_W'(rte_q[NUM_SRC-1:B0_W]);
      OFF_CTRL: rd_mux = DATA_W'(ctrl_q);
      OFF_TOP:  rd_mux = top_word;
      default: begin
        map_hit = pri_hit;
        rd_mux  = pri_rd;
      end
    endcase
  end

  assign bus_rdata_o = (bus_valid_i && !bus_write_i) ? rd_mux : '0;

  assert_unmapped_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && !bus_write_i && !map_hit) |-> (bus_rdata_o == '0));
  assert_reg_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr |=> ($stable(en_q) && $stable(rte_q) && $stable(ctrl_q)));
  assert_top_fiq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fiq_o |-> !top_word[15]);
  assert_top_irq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> !top_word[31]);
endmodule

// File: tb/tb_dual_bank_intc.sv
module tb_dual_bank_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [39:0] src = '0;
  logic        halted = 1'b0;
  logic        valid = 1'b0, write = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq, wake;
  int          checks = 0, errors = 0;

  always #2 clk = ~clk;

  dual_bank_intc dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .halted_i(halted),
    .bus_valid_i(valid), .bus_write_i(write), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .fiq_o(fiq), .wake_o(wake)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    valid = 1'b1; write = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0; write = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    @(negedge clk);
    valid = 1'b1; write = 1'b0; addr = a;
    #1 chk(req, rdata, exp);
    valid = 1'b0;
  endtask

  task automatic set_src(logic [39:0] v);
    @(negedge clk);
    src = v;
    @(negedge clk);
  endtask

  task automatic set_halt(logic v);
    @(negedge clk);
    halted = v;
    @(negedge clk);
  endtask

  task automatic t_reset;  // R11
    rd_chk("R11 en0", 8'h04, 0);
    rd_chk("R11 rte0", 8'h08, 0);
    rd_chk("R11 raw0", 8'h10, 0);
    rd_chk("R11 ctrl", 8'h14, 0);
    rd_chk("R11 prio0", 8'h1C, 0);
    rd_chk("R11 top", 8'h18, 32'h003F003F);
    chk("R11 lines", {29'b0, irq, fiq, wake}, 0);
  endtask

  task automatic t_map;  // R1 R2
    set_src(40'h08_0000_0020);
    rd_chk("R1 raw0", 8'h10, 32'h20);
    rd_chk("R1 raw1", 8'hAC, 32'h08);
    set_src(40'h08_0000_0000);
    rd_chk("R2 level drop", 8'h10, 32'h0);
    wr_reg(8'h10, 32'hFFFF_FFFF);
    wr_reg(8'hAC, 32'hFFFF_FFFF);
    rd_chk("R2 raw0 wr ignored", 8'h10, 32'h0);
    rd_chk("R2 raw1 wr ignored", 8'hAC, 32'h08);
  endtask

  task automatic t_lines;  // R3
    wr_reg(8'h04, 32'h20);
    set_src(40'h00_0000_0020);
    chk("R3 irq routed", {30'b0, irq, fiq}, 2'b10);
    wr_reg(8'h08, 32'h20);
    chk("R3 fiq routed", {30'b0, irq, fiq}, 2'b01);
    wr_reg(8'hA0, 32'h08);
    set_src(40'h08_0000_0020);
    chk("R3 both lines", {30'b0, irq, fiq}, 2'b11);
    set_src(40'h0);
    chk("R3 lines drop", {30'b0, irq, fiq}, 2'b00);
  endtask

  task automatic t_views;  // R4
    wr_reg(8'h04, 32'h60);
    wr_reg(8'h08, 32'h40);
    wr_reg(8'hA0, 32'h08);
    wr_reg(8'hA4, 32'h00);
    set_src(40'h08_0000_00E0);
    rd_chk("R4 irq0", 8'h00, 32'h20);
    rd_chk("R4 fiq0", 8'h0C, 32'h40);
    rd_chk("R4 irq1", 8'h9C, 32'h08);
    rd_chk("R4 fiq1", 8'hA8, 32'h00);
  endtask

  task automatic t_top;  // R9
    wr_reg(8'h1C, 32'h8000_0023);
    wr_reg(8'h20, 32'h8000_0006);
    wr_reg(8'h24, 32'h8000_0005);
    rd_chk("R9 top both", 8'h18, 32'h8023_8006);
    wr_reg(8'h1C, 32'h0000_0023);
    rd_chk("R9 invalid skipped", 8'h18, 32'h8005_8006);
    wr_reg(8'h1C, 32'h8000_002D);
    rd_chk("R9 id out of range", 8'h18, 32'h8005_8006);
    wr_reg(8'h18, 32'h0);
    rd_chk("R9 write ignored", 8'h18, 32'h8005_8006);
    wr_reg(8'h04, 32'h0);
    wr_reg(8'hA0, 32'h0);
    rd_chk("R9 none active", 8'h18, 32'h003F_003F);
  endtask

  task automatic t_regs;  // R5 R8
    wr_reg(8'hA0, 32'hFFFF_FFFF);
    rd_chk("R5 en1 width", 8'hA0, 32'hFF);
    wr_reg(8'hA4, 32'hFFFF_FF01);
    rd_chk("R5 rte1 width", 8'hA4, 32'h01);
    wr_reg(8'h08, 32'hA5A5_0000);
    rd_chk("R5 rte0", 8'h08, 32'hA5A5_0000);
    wr_reg(8'hCC, 32'hFFFF_FFFF);
    rd_chk("R8 entry39", 8'hCC, 32'h8000_003F);
    wr_reg(8'h98, 32'h1234_5678);
    rd_chk("R8 entry31", 8'h98, 32'h0000_0038);
    rd_chk("R8 entry32 untouched", 8'hB0, 32'h0);
    wr_reg(8'hA0, 32'h0);
    wr_reg(8'hA4, 32'h0);
    wr_reg(8'h08, 32'h0);
  endtask

  task automatic t_wake;  // R6 R7
    wr_reg(8'h04, 32'h0);
    set_src(40'h00_0000_0020);
    chk("R7 no wake while running", {31'b0, wake}, 0);
    set_halt(1'b1);
    chk("R6 idle-all wakes masked src", {31'b0, wake}, 1);
    wr_reg(8'h14, 32'h1);
    chk("R6 enabled-only blocks masked", {31'b0, wake}, 0);
    rd_chk("R6 ctrl readback", 8'h14, 32'h1);
    wr_reg(8'h04, 32'h20);
    chk("R6 enabled src wakes", {31'b0, wake}, 1);
    set_halt(1'b0);
    chk("R7 wake drops", {31'b0, wake}, 0);
    wr_reg(8'h14, 32'hFFFF_FFFE);
    rd_chk("R6 ctrl bit0 only", 8'h14, 32'h0);
  endtask

  task automatic t_unmapped;  // R10
    wr_reg(8'h04, 32'h0000_1111);
    wr_reg(8'hD0, 32'hDEAD_BEEF);
    wr_reg(8'h05, 32'hFFFF_FFFF);
    rd_chk("R10 unmapped read", 8'hD0, 32'h0);
    rd_chk("R10 unaligned read", 8'h06, 32'h0);
    rd_chk("R10 en0 untouched", 8'h04, 32'h0000_1111);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map();
    t_lines();
    t_views();
    t_top();
    t_regs();
    t_wake();
    t_unmapped();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule